// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the digital divide chain of a frequency synthesizer. A behavioural two-ratio prescaler runs on the fast (VCO-rate) clock and divides it either by P or by P+1, where P is 64 or 128. Two nested down-counters count the prescaler cycles. The swallow counter keeps the prescaler at P+1 for the first A prescaler cycles. The main counter closes the comparison period after N prescaler cycles. One comparison period therefore lasts P·N + A fast-clock cycles. The last cycle of each period raises the one-cycle pulse `fp`. A separate reference divider on the oscillator clock produces the pulse `fr` once every R oscillator cycles.

Ratio words come from a configuration register elsewhere and are held steady at the ports. The block samples them only at a period boundary: at the end of each period or on `restart`. A word that breaks the legal range is rejected, and the previous active ratio stays in force. `restart` is synchronous in each clock domain and returns every counter to the start of a period. Because of this, `fp` and `fr` start with a known phase relation. The outputs are free-running pulses with no handshake. They cannot be stalled, so there is no back-pressure.

The asynchronous reset `rst_n` serves both domains. It must be released synchronously to each clock. `restart` must be held for at least one edge of each clock.

Top module: `pls_divider`

## Requirements
- R1: With a valid ratio held steady, consecutive `fp` pulses are exactly P·N + A fast-clock cycles apart.
- R2: Within each comparison period, `mod_ctl` is high for exactly the first A·(P+1) fast-clock cycles and low for the rest of the period, including the `fp` cycle. It only rises in the cycle after `fp` or after `restart`.
- R3: `pair_sel` = 1 selects P = 64, and `pair_sel` = 0 selects P = 128. The selection takes effect together with N and A at a period boundary.
- R4: `n_word` is 11 bits wide and accepted from 3 to 2047. `a_word` is 7 bits wide and accepted from 0 to 127 when it is below N. A = 0 gives a period of P·N with `mod_ctl` never high.
- R5: If `n_word` < 3 or `a_word` ≥ `n_word` at a period boundary, the whole ratio (N, A and the pair select) is not taken, and the previous ratio keeps governing the period length.
- R6: `fr` pulses exactly R oscillator cycles apart. `r_word` is 14 bits wide, accepted from 3 to 16383, and sampled when each reference period ends.
- R7: If `r_word` < 3 at a reference boundary, it is ignored and the previous R is kept.
- R8: `fp` and `fr` are each high for exactly one cycle of their clock, in the last cycle of their period.
- R9: After a cycle with `restart` high, a new period starts in both domains. The first `fp` comes P·N + A cycles later and the first `fr` comes R cycles later, counted from the first cycle after `restart`.
- R10: Under reset, `fp`, `fr` and `mod_ctl` are low. The active ratio is N = 3, A = 0, P = 64 and R = 3, so the first `fp` comes 192 cycles after release and the first `fr` comes 3 cycles after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Fast clock, the behavioural stand-in for the VCO input |
| clk_osc | input | 1 | Oscillator clock for the reference divider |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| restart | input | 1 | Synchronous restart of all counters |
| n_word | input | 11 | Main counter ratio N |
| a_word | input | 7 | Swallow count A |
| pair_sel | input | 1 | Prescaler pair select: 1 for 64/65, 0 for 128/129 |
| r_word | input | 14 | Reference ratio R |
| mod_ctl | output | 1 | Modulus control: high while the prescaler divides by P+1 |
| fp | output | 1 | Comparison pulse from the feedback chain |
| fr | output | 1 | Reference pulse from the oscillator divider |

## Verification
The bench targets these corner cases, each with the failure it would expose:
- Swallow boundary. A design that decrements the swallow count one prescaler cycle early or late shows a period off by one and a wrong `mod_ctl` high time.
- A = 0. A design that skips this case keeps the prescaler at P+1 for a whole period.
- The two prescaler pairs. A design that applies the pair select immediately rather than at the boundary produces one period of mixed length.
- Rejected words (N below 3, A not below N, R below 3). A design that loads them produces a short or hung period.
- `restart`. A design that fails to clear the prescaler phase places the first `fp` and `fr` off their expected offsets.

// File: rtl/pls_pkg.sv
package pls_pkg;
  // smallest legal ratio for the main counter and the reference divider
  localparam int unsigned PLS_MIN_DIV = 3;
endpackage

// File: rtl/pls_prescaler.sv
// Behavioural dual-modulus prescaler: one cycle_end pulse per P or P+1 fast clocks.
module pls_prescaler #(
  parameter int unsigned P_SMALL = 64,
  parameter int unsigned P_LARGE = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic pair_small,
  input  logic swallow,
  output logic cycle_end
);
  localparam int unsigned CW = $clog2(P_LARGE + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  always_comb begin
    last = (pair_small ? CW'(P_SMALL) : CW'(P_LARGE)) - CW'(1) + CW'(swallow);
  end

  assign cycle_end = (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || cycle_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/pls_swallow_main.sv
// Swallow counter nested inside the main counter, with boundary admission of the ratio.
module pls_swallow_main
  import pls_pkg::*;
#(
  parameter int unsigned N_W       = 11,
  parameter int unsigned A_W       = 7,
  parameter int unsigned DEF_N     = 3,
  parameter int unsigned DEF_A     = 0,
  parameter bit          DEF_SMALL = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic           cycle_end,
  input  logic [N_W-1:0] n_word,
  input  logic [A_W-1:0] a_word,
  input  logic           sel_word,
  output logic           swallow,
  output logic           pair_small,
  output logic           fp
);
  logic [N_W-1:0] n_act, n_cnt;
  logic [A_W-1:0] a_act, a_cnt;
  logic           small_act;
  logic           words_ok;
  logic           term;
  logic           load;

  assign words_ok   = (n_word >= N_W'(PLS_MIN_DIV)) && (32'(a_word) < 32'(n_word));
  assign term       = cycle_end && (n_cnt == N_W'(1));
  assign load       = restart || term;
  assign swallow    = (a_cnt != '0);
  assign pair_small = small_act;
  assign fp         = term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_act     <= N_W'(DEF_N);
      a_act     <= A_W'(DEF_A);
      small_act <= DEF_SMALL;
      n_cnt     <= N_W'(DEF_N);
      a_cnt     <= A_W'(DEF_A);
    end else if (load) begin
      if (words_ok) begin
        n_act     <= n_word;
        a_act     <= a_word;
        small_act <= sel_word;
        n_cnt     <= n_word;
        a_cnt     <= a_word;
      end else begin
        n_cnt <= n_act;
        a_cnt <= a_act;
      end
    end else if (cycle_end) begin
      n_cnt <= n_cnt - N_W'(1);
      if (a_cnt != '0) begin
        a_cnt <= a_cnt - A_W'(1);
      end
    end
  end
endmodule

// File: rtl/pls_ref_divider.sv
// Reference divider on the oscillator clock.
module pls_ref_divider
  import pls_pkg::*;
#(
  parameter int unsigned R_W   = 14,
  parameter int unsigned DEF_R = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic [R_W-1:0] r_word,
  output logic           fr
);
  logic [R_W-1:0] r_act, r_cnt;
  logic           tc;
  logic           r_ok;

  assign tc   = (r_cnt == R_W'(1));
  assign r_ok = (r_word >= R_W'(PLS_MIN_DIV));
  assign fr   = tc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_act <= R_W'(DEF_R);
      r_cnt <= R_W'(DEF_R);
    end else if (restart || tc) begin
      if (r_ok) begin
        r_act <= r_word;
        r_cnt <= r_word;
      end else begin
        r_cnt <= r_act;
      end
    end else begin
      r_cnt <= r_cnt - R_W'(1);
    end
  end
endmodule

// File: rtl/pls_divider.sv
module pls_divider #(
  parameter int unsigned N_W       = 11,
  parameter int unsigned A_W       = 7,
  parameter int unsigned R_W       = 14,
  parameter int unsigned P_SMALL   = 64,
  parameter int unsigned P_LARGE   = 128,
  parameter int unsigned DEF_N     = 3,
  parameter int unsigned DEF_A     = 0,
  parameter bit          DEF_SMALL = 1'b1,
  parameter int unsigned DEF_R     = 3
) (
  input  logic           clk_vco,
  input  logic           clk_osc,
  input  logic           rst_n,
  input  logic           restart,
  input  logic [N_W-1:0] n_word,
  input  logic [A_W-1:0] a_word,
  input  logic           pair_sel,
  input  logic [R_W-1:0] r_word,
  output logic           mod_ctl,
  output logic           fp,
  output logic           fr
);
  logic cycle_end;
  logic swallow;
  logic pair_small;

  pls_prescaler #(
    .P_SMALL (P_SMALL),
    .P_LARGE (P_LARGE)
  ) u_pre (
    .clk        (clk_vco),
    .rst_n      (rst_n),
    .restart    (restart),
    .pair_small (pair_small),
    .swallow    (swallow),
    .cycle_end  (cycle_end)
  );

  pls_swallow_main #(
    .N_W       (N_W),
    .A_W       (A_W),
    .DEF_N     (DEF_N),
    .DEF_A     (DEF_A),
    .DEF_SMALL (DEF_SMALL)
  ) u_cnt (
    .clk        (clk_vco),
    .rst_n      (rst_n),
    .restart    (restart),
    .cycle_end  (cycle_end),
    .n_word     (n_word),
    .a_word     (a_word),
    .sel_word   (pair_sel),
    .swallow    (swallow),
    .pair_small (pair_small),
    .fp         (fp)
  );

  pls_ref_divider #(
    .R_W   (R_W),
    .DEF_R (DEF_R)
  ) u_ref (
    .clk     (clk_osc),
    .rst_n   (rst_n),
    .restart (restart),
    .r_word  (r_word),
    .fr      (fr)
  );

  assign mod_ctl = swallow;
endmodule

// File: rtl/pls_divider_chk.sv
module pls_divider_chk (
  input logic clk_vco,
  input logic clk_osc,
  input logic rst_n,
  input logic restart,
  input logic mod_ctl,
  input logic fp,
  input logic fr
);
  p_fp_single_r8: assert property (@(posedge clk_vco) disable iff (!rst_n)
    fp |=> !fp);

  p_fr_single_r8: assert property (@(posedge clk_osc) disable iff (!rst_n)
    fr |=> !fr);

  p_mod_low_at_fp_r2: assert property (@(posedge clk_vco) disable iff (!rst_n)
    fp |-> !mod_ctl);

  p_mod_rise_start_r2: assert property (@(posedge clk_vco) disable iff (!rst_n)
    $rose(mod_ctl) |-> ($past(fp) || $past(restart)));

  p_restart_fp_r9: assert property (@(posedge clk_vco) disable iff (!rst_n)
    restart |=> !fp);

  p_restart_fr_r9: assert property (@(posedge clk_osc) disable iff (!rst_n)
    restart |=> !fr);
endmodule

bind pls_divider pls_divider_chk u_chk (
  .clk_vco (clk_vco),
  .clk_osc (clk_osc),
  .rst_n   (rst_n),
  .restart (restart),
  .mod_ctl (mod_ctl),
  .fp      (fp),
  .fr      (fr)
);

// File: tb/pls_divider_tb.sv
module pls_divider_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        restart = 1'b0;
  logic [10:0] n_word = '0;
  logic [6:0]  a_word = '0;
  logic        pair_sel = 1'b0;
  logic [13:0] r_word = '0;
  logic        mod_ctl, fp, fr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pls_divider u_dut (
    .clk_vco  (clk),
    .clk_osc  (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .n_word   (n_word),
    .a_word   (a_word),
    .pair_sel (pair_sel),
    .r_word   (r_word),
    .mod_ctl  (mod_ctl),
    .fp       (fp),
    .fr       (fr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference: phase index within each period
  int t = 0, s = 0;
  int mn = 3, ma = 0, msel = 1, mr = 3;

  function automatic int pval(input int sel);
    return sel != 0 ? 64 : 128;
  endfunction

  function automatic int ptot();
    return pval(msel) * mn + ma;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mn = 3; ma = 0; msel = 1; mr = 3; t = 0; s = 0;
    end else begin
      if (restart || t == ptot() - 1) begin
        if (int'(n_word) >= 3 && int'(a_word) < int'(n_word)) begin
          mn = int'(n_word); ma = int'(a_word); msel = int'(pair_sel);
        end
        t = 0;
      end else begin
        t++;
      end
      if (restart || s == mr - 1) begin
        if (int'(r_word) >= 3) mr = int'(r_word);
        s = 0;
      end else begin
        s++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 fp per-cycle", int'(fp), int'(t == ptot() - 1));
      chk("R2 mod_ctl per-cycle", int'(mod_ctl), int'(t < ma * (pval(msel) + 1)));
      chk("R6 fr per-cycle", int'(fr), int'(s == mr - 1));
    end
  end

  task automatic fp_period(output int gap, output int mh);
    while (!fp) @(negedge clk);
    gap = 0; mh = 0;
    do begin
      @(negedge clk);
      gap++;
      if (mod_ctl && !fp) mh++;
    end while (!fp);
  endtask

  task automatic fr_period(output int gap);
    while (!fr) @(negedge clk);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!fr);
  endtask

  task automatic to_first(output int cfp, output int cfr);
    int c = 1;
    cfp = -1; cfr = -1;
    while (cfp < 0 || cfr < 0) begin
      if (fp && cfp < 0) cfp = c;
      if (fr && cfr < 0) cfr = c;
      if (cfp < 0 || cfr < 0) begin
        @(negedge clk);
        c++;
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int g, mh, cfp, cfr;
    n_word = 11'd5; a_word = 7'd2; pair_sel = 1'b1; r_word = 14'd10;
    repeat (3) @(negedge clk);
    chk("R10 fp in reset", int'(fp), 0);
    chk("R10 fr in reset", int'(fr), 0);
    chk("R10 mod_ctl in reset", int'(mod_ctl), 0);
    rst_n = 1'b1;
    to_first(cfp, cfr);
    chk("R10 first fp offset", cfp, 192);
    chk("R10 first fr offset", cfr, 3);

    fp_period(g, mh);
    chk("R1 period sel1 N5 A2", g, 322);
    chk("R2 swallow cycles N5 A2", mh, 130);
    fr_period(g);
    chk("R6 fr period R10", g, 10);

    n_word = 11'd4; a_word = 7'd3; pair_sel = 1'b0;
    fp_period(g, mh);
    chk("R3 period sel0 N4 A3", g, 515);
    chk("R3 swallow cycles sel0", mh, 387);

    n_word = 11'd2; a_word = 7'd0; pair_sel = 1'b1;
    fp_period(g, mh);
    chk("R5 N below 3 ignored", g, 515);

    n_word = 11'd4; a_word = 7'd4; pair_sel = 1'b1;
    fp_period(g, mh);
    chk("R5 A not below N ignored", g, 515);
    chk("R5 swallow kept", mh, 387);

    n_word = 11'd3; a_word = 7'd0; pair_sel = 1'b0;
    fp_period(g, mh);
    chk("R4 N3 A0 period", g, 384);
    chk("R4 A0 no swallow", mh, 0);

    n_word = 11'd128; a_word = 7'd127; pair_sel = 1'b1;
    fp_period(g, mh);
    chk("R4 A127 period", g, 8319);
    chk("R4 A127 swallow", mh, 8255);

    r_word = 14'd3;
    fr_period(g);
    chk("R6 fr minimum R3", g, 3);
    r_word = 14'd2;
    fr_period(g);
    chk("R7 R2 ignored", g, 3);
    r_word = 14'd0;
    fr_period(g);
    chk("R7 R0 ignored", g, 3);
    r_word = 14'd1000;
    fr_period(g);
    chk("R6 fr R1000", g, 1000);

    n_word = 11'd6; a_word = 7'd5; pair_sel = 1'b1; r_word = 14'd50;
    repeat (7) @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    to_first(cfp, cfr);
    chk("R9 fp after restart", cfp, 389);
    chk("R9 fr after restart", cfr, 50);
    fp_period(g, mh);
    chk("R1 period after restart", g, 389);
    chk("R2 swallow after restart", mh, 325);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule